// File: doc/BRIEF.md
# Ethernet link mode resolver

This block decides the speed (10 or 100 Mb/s) and the duplex of one Ethernet port. It holds a 16-bit control word that a host writes. The word carries an auto-negotiation enable, a self-clearing restart, a manual speed bit and a manual duplex bit. While negotiation is enabled, the block compares the local capability word with the capability word that the link partner has advertised. It then picks the best mode that both sides share. If the partner does not negotiate, the block takes the speed from the parallel-detect indication and forces half duplex.

With negotiation disabled, the manual bits choose the speed and the duplex directly. The block reports four things: the resolved speed and duplex, a done flag, and a compact 3-bit mode code. The partner's last capability word and whether that partner negotiates are kept for the host to read. Pulse generation, pulse decoding and line coding are outside the block, so partner data arrives as decoded words with a strobe.

Top module: `lmr_link_resolver`

## Requirements
- R1: Out of reset the control readback is 16'h1000 (negotiation enabled, all else clear), the done flag is 0, the mode code is 3'b000, the partner capability register is 0 and the partner-negotiates status is 0.
- R2: Capability words use bit 0 = 10 half, bit 1 = 10 full, bit 2 = 100 half, bit 3 = 100 full. With negotiation enabled, a strobe from a negotiating partner resolves the highest common mode in the order 100 full, 100 half, 10 full, 10 half. The done flag is then set from the cycle after the strobe.
- R3: If the local and partner words share no mode, a negotiating-partner strobe leaves done at 0 and the mode code at 3'b000.
- R4: A strobe from a partner that does not negotiate sets done. It also takes the speed from the parallel-detect input and always selects half duplex.
- R5: With the enable bit (bit 12) clear, the speed bit (bit 13) selects 100 when set and 10 when clear. The duplex bit (bit 8) selects full when set and half when clear. Done reads 0 in this mode.
- R6: Writing 1 to the restart bit (bit 9) while negotiation is enabled clears done and the mode code on the next cycle. The restart wins over a partner strobe in the same cycle, and bit 9 always reads back 0.
- R7: Mode codes are 3'b000 none, 3'b001 10 half, 3'b101 10 full, 3'b010 100 half and 3'b110 100 full. The speed100 output equals code bit 1 and the full_duplex output equals code bit 2.
- R8: Every strobe latches the partner capability word and the partner-negotiates flag into readable outputs.
- R9: While negotiation is enabled, writes that change only the manual speed and duplex bits leave the mode code, the done flag, the speed and the duplex unchanged.
- R10: The control readback returns the last written word with bit 9 cleared.
- R11: Clearing the enable bit discards the negotiated result. Re-enabling it without a new strobe reports done 0 and code 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Control word readback |
| local_cap | input | 4 | Local advertised capabilities |
| lp_cap | input | 4 | Partner capability word |
| lp_cap_valid | input | 1 | Partner word strobe |
| lp_neg_able | input | 1 | Partner takes part in negotiation |
| pd_speed100 | input | 1 | Parallel-detect speed, 1 = 100 Mb/s |
| speed100 | output | 1 | Resolved speed is 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex is full |
| an_done | output | 1 | Negotiation complete |
| mode_code | output | 3 | Resolved mode code |
| lp_cap_reg | output | 4 | Latched partner capability word |
| lp_an_able | output | 1 | Latched partner-negotiates status |

## Verification
The bench aims at the priority edges, for example local 0111 against partner 1111. A resolver that took the partner's best mode instead of the common one would report 100 full there. It also covers disjoint capability sets, where a faulty design would raise done with a bogus code, and a non-negotiating partner that advertises full duplex, where a wrong design would select full. Finally it checks a restart in the same cycle as a strobe, manual-bit writes while negotiation is enabled, and re-enabling after manual mode, where a design that kept stale state would report an old mode.

// File: rtl/lmr_pkg.sv
// Package for the link mode resolver: mode code type, code values and
// capability bit indices. Assumes a four-mode capability word.
package lmr_pkg;
    typedef logic [2:0] mode_code_t;

    localparam mode_code_t CODE_NONE = 3'b000;
    localparam mode_code_t CODE_10H  = 3'b001;
    localparam mode_code_t CODE_10F  = 3'b101;
    localparam mode_code_t CODE_100H = 3'b010;
    localparam mode_code_t CODE_100F = 3'b110;

    localparam int CAP_10H  = 0;
    localparam int CAP_10F  = 1;
    localparam int CAP_100H = 2;
    localparam int CAP_100F = 3;

    // Map a capability bit index to its mode code.
    function automatic mode_code_t cap_to_code(input int idx);
        case (idx)
            CAP_10H:  return CODE_10H;
            CAP_10F:  return CODE_10F;
            CAP_100H: return CODE_100H;
            CAP_100F: return CODE_100F;
            default:  return CODE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/lmr_ctrl.sv
// Control word register. It holds the host-written word and forces the
// restart bit to read 0. A write with the restart bit set produces a
// restart request in the same cycle.
// Assumes one writer and bit positions given by parameters.
module lmr_ctrl #(
    parameter int CTRL_W  = 16,
    parameter int SPD_BIT = 13,
    parameter int EN_BIT  = 12,
    parameter int RST_BIT = 9,
    parameter int DPX_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              an_en,
    output logic              man_spd,
    output logic              man_dpx,
    output logic              restart_req
);
    localparam logic [CTRL_W-1:0] RESET_VAL = CTRL_W'(1) << EN_BIT;
    localparam logic [CTRL_W-1:0] KEEP_MASK = ~(CTRL_W'(1) << RST_BIT);

    // Store the written word; the restart bit is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RESET_VAL;
        else if (wr)
            ctrl_q <= wdata & KEEP_MASK;
    end

    // Decode the fields and the restart request.
    always_comb begin
        an_en       = ctrl_q[EN_BIT];
        man_spd     = ctrl_q[SPD_BIT];
        man_dpx     = ctrl_q[DPX_BIT];
        restart_req = wr & wdata[RST_BIT];
    end

    // R10
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ctrl_q == ($past(wdata) & KEEP_MASK));

    // R6
    restart_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && wdata[RST_BIT] |=> !ctrl_q[RST_BIT]);
endmodule

// File: rtl/lmr_pick.sv
// Priority picker. It finds the highest common mode of two capability
// words, where a higher bit index has higher priority.
// Assumes that index order equals mode preference.
module lmr_pick
    import lmr_pkg::*;
#(
    parameter int N_MODES = 4
) (
    input  logic [N_MODES-1:0] local_cap,
    input  logic [N_MODES-1:0] lp_cap,
    output logic               found,
    output mode_code_t         code
);
    logic [N_MODES-1:0] common;
    logic [N_MODES:0]   above;
    logic [N_MODES-1:0] pick;

    assign common        = local_cap & lp_cap;
    assign above[N_MODES] = 1'b0;

    genvar gi;
    generate
        for (gi = N_MODES - 1; gi >= 0; gi--) begin : g_prio
            // A bit is chosen only when no higher bit is in common.
            assign above[gi] = above[gi+1] | common[gi];
            assign pick[gi]  = common[gi] & ~above[gi+1];
        end
    endgenerate

    // Turn the one-hot choice into a mode code.
    always_comb begin
        code  = CODE_NONE;
        found = |common;
        for (int i = 0; i < N_MODES; i++)
            if (pick[i]) code = code | cap_to_code(i);
    end
endmodule

// File: rtl/lmr_an_track.sv
// Negotiation tracker. It holds the done flag, the negotiated code, the
// latched partner word and the partner-negotiates status.
// Assumes partner data arrives decoded, with a one-cycle strobe.
module lmr_an_track
    import lmr_pkg::*;
#(
    parameter int N_MODES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               an_en,
    input  logic               restart_req,
    input  logic               lp_valid,
    input  logic               lp_neg,
    input  logic               pd_100,
    input  logic [N_MODES-1:0] lp_cap_in,
    input  logic               pick_found,
    input  mode_code_t         pick_code,
    output logic               done,
    output mode_code_t         code,
    output logic [N_MODES-1:0] lp_cap_q,
    output logic               lp_an_ok
);
    // Negotiation result: cleared when disabled or restarted, set on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !an_en || restart_req) begin
            done <= 1'b0;
            code <= CODE_NONE;
        end else if (lp_valid) begin
            if (lp_neg) begin
                done <= pick_found;
                code <= pick_found ? pick_code : CODE_NONE;
            end else begin
                done <= 1'b1;
                code <= pd_100 ? CODE_100H : CODE_10H;
            end
        end
    end

    // Latch the partner word and its negotiation status on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_cap_q <= '0;
            lp_an_ok <= 1'b0;
        end else if (lp_valid) begin
            lp_cap_q <= lp_cap_in;
            lp_an_ok <= lp_neg;
        end
    end

    // R4
    pd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_en && !restart_req && lp_valid && !lp_neg
        |=> done && !code[2] && (code[1] == $past(pd_100)));

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_en && restart_req |=> !done && code == CODE_NONE);

    // R7
    code_speed_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot(code[1:0]));

    // R8
    lp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_valid |=> lp_cap_q == $past(lp_cap_in) && lp_an_ok == $past(lp_neg));
endmodule

// File: rtl/lmr_link_resolver.sv
// Link mode resolver top. It selects between the negotiated result and
// the manual control bits, and drives the speed, duplex, done and code
// outputs. Assumes a 16-bit control word and a four-mode capability word.
module lmr_link_resolver
    import lmr_pkg::*;
#(
    parameter int CTRL_W  = 16,
    parameter int N_MODES = 4,
    parameter int SPD_BIT = 13,
    parameter int EN_BIT  = 12,
    parameter int RST_BIT = 9,
    parameter int DPX_BIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    output logic [CTRL_W-1:0]  ctrl_rdata,
    input  logic [N_MODES-1:0] local_cap,
    input  logic [N_MODES-1:0] lp_cap,
    input  logic               lp_cap_valid,
    input  logic               lp_neg_able,
    input  logic               pd_speed100,
    output logic               speed100,
    output logic               full_duplex,
    output logic               an_done,
    output logic [2:0]         mode_code,
    output logic [N_MODES-1:0] lp_cap_reg,
    output logic               lp_an_able
);
    logic       an_en, man_spd, man_dpx, restart_req;
    logic       pick_found, neg_done;
    mode_code_t pick_code, neg_code, out_code;

    lmr_ctrl #(
        .CTRL_W(CTRL_W), .SPD_BIT(SPD_BIT), .EN_BIT(EN_BIT),
        .RST_BIT(RST_BIT), .DPX_BIT(DPX_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
        .ctrl_q(ctrl_rdata), .an_en(an_en), .man_spd(man_spd),
        .man_dpx(man_dpx), .restart_req(restart_req)
    );

    lmr_pick #(.N_MODES(N_MODES)) u_pick (
        .local_cap(local_cap), .lp_cap(lp_cap),
        .found(pick_found), .code(pick_code)
    );

    lmr_an_track #(.N_MODES(N_MODES)) u_track (
        .clk(clk), .rst_n(rst_n), .an_en(an_en), .restart_req(restart_req),
        .lp_valid(lp_cap_valid), .lp_neg(lp_neg_able), .pd_100(pd_speed100),
        .lp_cap_in(lp_cap), .pick_found(pick_found), .pick_code(pick_code),
        .done(neg_done), .code(neg_code), .lp_cap_q(lp_cap_reg),
        .lp_an_ok(lp_an_able)
    );

    // Choose the negotiated result or the manual selection.
    always_comb begin
        if (an_en) begin
            out_code = neg_code;
            an_done  = neg_done;
        end else begin
            out_code = {man_dpx, man_spd, ~man_spd};
            an_done  = 1'b0;
        end
        mode_code   = out_code;
        speed100    = out_code[1];
        full_duplex = out_code[2];
    end

    // R5
    manual_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !an_en |-> !an_done);

    // R9
    manual_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_en && ctrl_wr && ctrl_wdata[EN_BIT] && !ctrl_wdata[RST_BIT] && !lp_cap_valid
        |=> $stable(mode_code) && $stable(an_done));
endmodule

// File: tb/lmr_link_resolver_test.sv
module lmr_link_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_wr;
    logic [15:0] ctrl_wdata;
    logic [15:0] ctrl_rdata;
    logic [3:0]  local_cap, lp_cap;
    logic        lp_cap_valid, lp_neg_able, pd_speed100;
    logic        speed100, full_duplex, an_done;
    logic [2:0]  mode_code;
    logic [3:0]  lp_cap_reg;
    logic        lp_an_able;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model state
    bit       m_en;
    bit       m_spd, m_dpx;
    bit       m_tdone;
    bit [2:0] m_tcode;
    bit [15:0] m_ctrl;
    bit [3:0] m_lpcap;
    bit       m_lpneg;

    always #4 clk = ~clk;

    lmr_link_resolver uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .local_cap(local_cap), .lp_cap(lp_cap),
        .lp_cap_valid(lp_cap_valid), .lp_neg_able(lp_neg_able),
        .pd_speed100(pd_speed100), .speed100(speed100),
        .full_duplex(full_duplex), .an_done(an_done), .mode_code(mode_code),
        .lp_cap_reg(lp_cap_reg), .lp_an_able(lp_an_able)
    );

    // Highest common mode by the stated order; 0 if none.
    function automatic bit [2:0] exp_pick(input bit [3:0] a, input bit [3:0] b);
        bit [3:0] c = a & b;
        if (c[3]) return 3'b110;
        if (c[2]) return 3'b010;
        if (c[1]) return 3'b101;
        if (c[0]) return 3'b001;
        return 3'b000;
    endfunction

    function automatic bit [2:0] exp_code();
        if (m_en) return m_tcode;
        return {m_dpx, m_spd, ~m_spd};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output with the bench model.
    task automatic check_all(input string req);
        bit [2:0] c = exp_code();
        chk({req, " code"}, 16'(mode_code), 16'(c));
        chk({req, " done"}, 16'(an_done), 16'(m_en & m_tdone));
        chk({req, " R7 speed"}, 16'(speed100), 16'(c[1]));
        chk({req, " R7 duplex"}, 16'(full_duplex), 16'(c[2]));
        chk({req, " R10 ctrl"}, ctrl_rdata, m_ctrl);
        chk({req, " R8 lpcap"}, 16'(lp_cap_reg), 16'(m_lpcap));
        chk({req, " R8 lpneg"}, 16'(lp_an_able), 16'(m_lpneg));
    endtask

    task automatic do_write(input bit [15:0] w);
        bit old_en = m_en;
        ctrl_wr = 1'b1; ctrl_wdata = w;
        @(posedge clk); @(negedge clk);
        ctrl_wr = 1'b0;
        if (!old_en || w[9]) begin m_tdone = 0; m_tcode = 3'b000; end
        m_ctrl = w & 16'hFDFF;
        m_en = w[12]; m_spd = w[13]; m_dpx = w[8];
    endtask

    task automatic do_strobe(input bit [3:0] loc, input bit [3:0] lp,
                             input bit neg, input bit pd);
        local_cap = loc; lp_cap = lp; lp_neg_able = neg; pd_speed100 = pd;
        lp_cap_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        lp_cap_valid = 1'b0;
        m_lpcap = lp; m_lpneg = neg;
        if (!m_en) begin m_tdone = 0; m_tcode = 3'b000; end
        else if (neg) begin
            m_tcode = exp_pick(loc, lp);
            m_tdone = (m_tcode != 3'b000);
        end else begin
            m_tdone = 1; m_tcode = pd ? 3'b010 : 3'b001;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; ctrl_wr = 0; ctrl_wdata = 0; local_cap = 0; lp_cap = 0;
        lp_cap_valid = 0; lp_neg_able = 0; pd_speed100 = 0;
        m_en = 1; m_spd = 0; m_dpx = 0; m_tdone = 0; m_tcode = 0;
        m_ctrl = 16'h1000; m_lpcap = 0; m_lpneg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); @(negedge clk);
        check_all("R1 reset");

        // R2 priority cases
        do_strobe(4'b1111, 4'b1111, 1, 0); check_all("R2 all");
        chk("R2 100F", 16'(mode_code), 16'h6);
        do_strobe(4'b0111, 4'b1111, 1, 0); check_all("R2 100H");
        do_strobe(4'b1011, 4'b0011, 1, 1); check_all("R2 10F");
        do_strobe(4'b0001, 4'b1111, 1, 1); check_all("R2 10H");
        // R3 disjoint
        do_strobe(4'b1100, 4'b0011, 1, 1); check_all("R3 none");
        chk("R3 done", 16'(an_done), 16'h0);
        // R4 parallel detect, full advertised but half forced
        do_strobe(4'b1111, 4'b1111, 0, 1); check_all("R4 pd100");
        chk("R4 half", 16'(full_duplex), 16'h0);
        do_strobe(4'b1111, 4'b0010, 0, 0); check_all("R4 pd10");

        // R6 restart
        do_strobe(4'b1111, 4'b1111, 1, 0);
        do_write(16'h1200); check_all("R6 restart");
        chk("R6 reads0", ctrl_rdata, 16'h1000);
        // R6 restart with same-cycle strobe
        local_cap = 4'b1111; lp_cap = 4'b1111; lp_neg_able = 1; lp_cap_valid = 1;
        ctrl_wr = 1; ctrl_wdata = 16'h1200;
        @(posedge clk); @(negedge clk);
        ctrl_wr = 0; lp_cap_valid = 0;
        m_lpcap = 4'b1111; m_lpneg = 1; m_tdone = 0; m_tcode = 0;
        check_all("R6 restart wins");

        // R9 manual bits ignored while enabled
        do_strobe(4'b1111, 4'b1111, 1, 0);
        do_write(16'h1000); check_all("R9 clear bits");
        chk("R9 code kept", 16'(mode_code), 16'h6);
        do_strobe(4'b0001, 4'b0001, 1, 0);
        do_write(16'h3100); check_all("R9 set bits");
        chk("R9 code kept2", 16'(mode_code), 16'h1);

        // R5 manual mode
        do_write(16'h2100); check_all("R5 100F");
        chk("R5 code", 16'(mode_code), 16'h6);
        do_write(16'h0000); check_all("R5 10H");
        do_write(16'h0100); check_all("R5 10F");
        do_write(16'h2000); check_all("R5 100H");
        do_strobe(4'b1111, 4'b1111, 1, 0); check_all("R5 strobe in manual");
        // R11 re-enable gives clean state
        do_write(16'h1000); check_all("R11 reenable");
        chk("R11 code", 16'(mode_code), 16'h0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 4);
            if (op <= 2) begin
                do_strobe(4'($urandom), 4'($urandom), 1'($urandom_range(0, 3) != 0),
                          1'($urandom));
                check_all("R2 R4 random strobe");
            end else if (op == 3) begin
                bit [15:0] w = 16'($urandom) & 16'hF3FF;
                w[12] = ($urandom_range(0, 3) != 0);
                w[9] = ($urandom_range(0, 3) == 0);
                do_write(w);
                check_all("R5 R6 R10 random write");
            end else begin
                @(posedge clk); @(negedge clk);
                if (!m_en) begin m_tdone = 0; m_tcode = 0; end
                check_all("R9 random idle");
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule